// File: doc/BRIEF.md
# Multi-level delay code stepper

This block holds the delay code of one byte lane as four nested fields: a one-bit coarse field, a clock-delay field, a tap field and a phase-interpolator step. A training sequencer sweeps the lane's strobe or data timing by pulsing a one-cycle up or down command. The stepper moves the code by exactly one position, carrying into or borrowing from the wider fields as needed. The number of taps per clock-delay position depends on the memory speed grade, so the sweep length changes with that grade.

Two deboost control bits follow the code. They are recomputed from speed-dependent tap and interpolator thresholds whenever a new code is loaded or a step succeeds. A step that would leave the legal range changes nothing and raises a one-cycle error pulse. Issuing both commands together is treated as a protocol fault: nothing moves and a separate pulse flags it. A load strobe seeds the code with any starting value, for example the result of an earlier training pass. All outputs are registered and appear in the cycle after the command edge.

Top module: `dly_code_stepper`

## Requirements
- R1: While reset is asserted and after it is released, the code reads coarse 0, clock-delay 0, tap 0 and interpolator 0, with boost_en 1, boost_sel 1, and both error pulses 0.
- R2: A load strobe writes all four fields from the load inputs at the next edge and recomputes the deboost bits. A load takes priority over any step command in the same cycle, and no error pulse is raised.
- R3: An up command picks the first case that applies: interpolator below 6 → interpolator +1; else tap below the grade maximum → interpolator 0, tap +1; else clock-delay below 2 → interpolator 0, tap 0, clock-delay +1; else coarse 0 → interpolator 0, tap 0, clock-delay −1, coarse 1; else the step fails.
- R4: A down command picks the first case that applies: interpolator above 0 → interpolator −1; else tap above 0 → interpolator 6, tap −1; else clock-delay above 0 → interpolator 6, tap at the grade maximum, clock-delay −1; else coarse 1 → interpolator 6, tap at the grade maximum, clock-delay +1, coarse 0; else the step fails.
- R5: The grade maximum tap is 12 for speed code 0, 10 for code 1, 13 for code 2, and 12 for code 3. A full sweep from the all-zero code to the top code therefore takes 35·(max+1)−1 successful steps.
- R6: Each speed code has thresholds (t0, t1, p0, p1): (3, 10, 2, 3) for codes 0 and 3, (2, 8, 6, 7) for code 1, and (3, 11, 6, 4) for code 2. If tap < t0, or tap = t0 and interpolator < p0, then en=1 and sel=1. Otherwise, if tap < t1, or tap = t1 and interpolator < p1, then en=0 and sel=0. In every other case en=1 and sel=0.
- R7: The deboost bits change only on a load or a successful step. A cycle with no command, or a change of the speed code alone, leaves the code and the deboost bits unchanged.
- R8: A failed step leaves all four fields and the deboost bits unchanged and raises step_err for exactly one cycle.
- R9: If up and down are both asserted without a load, nothing changes and proto_err is raised for one cycle. step_err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | SPD_W | Speed grade code (0, 1, 2; 3 behaves as 0) |
| step_up | input | 1 | One-cycle increment command |
| step_dn | input | 1 | One-cycle decrement command |
| load_stb | input | 1 | Load strobe for a full code |
| load_coarse | input | 1 | Coarse value to load |
| load_clk | input | CLK_W | Clock-delay value to load |
| load_tap | input | TAP_W | Tap value to load |
| load_pi | input | PI_W | Interpolator value to load |
| out_coarse | output | 1 | Current coarse field |
| out_clk | output | CLK_W | Current clock-delay field |
| out_tap | output | TAP_W | Current tap field |
| out_pi | output | PI_W | Current interpolator field |
| boost_en | output | 1 | Deboost enable bit |
| boost_sel | output | 1 | Deboost select bit |
| step_err | output | 1 | One-cycle pulse on a step that cannot be taken |
| proto_err | output | 1 | One-cycle pulse when up and down arrive together |

## Verification
Three events can land on the same edge: a load, an up command and a down command. The bench provokes all three together and expects the load to win with no pulse. It also drives up and down without a load and expects proto_err with the code frozen. A failed step at either end of the range is driven in its own cycle, and the following idle cycle must show both pulses cleared. This separates the one-cycle step error from the protocol fault and from a lingering flag.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;

   localparam int GRADE_N   = 3;
   localparam int LIM_TAP_W = 4;
   localparam int LIM_PI_W  = 3;

   typedef struct packed {
      logic [LIM_TAP_W-1:0] tap_max;
      logic [LIM_TAP_W-1:0] tap_lo;
      logic [LIM_TAP_W-1:0] tap_hi;
      logic [LIM_PI_W-1:0]  pi_lo;
      logic [LIM_PI_W-1:0]  pi_hi;
   } grade_lim_t;

   // index 0: slowest grade, also the fallback for unknown codes
   localparam grade_lim_t GRADE_LIM [GRADE_N] = '{
      '{tap_max: 4'd12, tap_lo: 4'd3, tap_hi: 4'd10, pi_lo: 3'd2, pi_hi: 3'd3},
      '{tap_max: 4'd10, tap_lo: 4'd2, tap_hi: 4'd8,  pi_lo: 3'd6, pi_hi: 3'd7},
      '{tap_max: 4'd13, tap_lo: 4'd3, tap_hi: 4'd11, pi_lo: 3'd6, pi_hi: 3'd4}
   };

endpackage

// File: rtl/dly_speed_table.sv
module dly_speed_table
   import dly_step_pkg::*;
#(
   parameter int SPD_W = 2,
   parameter int TAP_W = 4,
   parameter int PI_W  = 3
) (
   input  logic [SPD_W-1:0] speed_sel,
   output logic [TAP_W-1:0] tap_max,
   output logic [TAP_W-1:0] th_tap_lo,
   output logic [TAP_W-1:0] th_tap_hi,
   output logic [PI_W-1:0]  th_pi_lo,
   output logic [PI_W-1:0]  th_pi_hi
);

   if (TAP_W < LIM_TAP_W) begin : g_tap_w_bad
      $error("dly_speed_table: TAP_W too narrow for the grade table");
   end
   if (PI_W < LIM_PI_W) begin : g_pi_w_bad
      $error("dly_speed_table: PI_W too narrow for the grade table");
   end

   grade_lim_t sel_lim;

   always_comb begin
      sel_lim = GRADE_LIM[0];
      for (int g = 1; g < GRADE_N; g++) begin
         if (int'(speed_sel) == g) sel_lim = GRADE_LIM[g];
      end
   end

   assign tap_max   = TAP_W'(sel_lim.tap_max);
   assign th_tap_lo = TAP_W'(sel_lim.tap_lo);
   assign th_tap_hi = TAP_W'(sel_lim.tap_hi);
   assign th_pi_lo  = PI_W'(sel_lim.pi_lo);
   assign th_pi_hi  = PI_W'(sel_lim.pi_hi);

endmodule

// File: rtl/dly_step_path.sv
module dly_step_path #(
   parameter bit DIR_UP  = 1'b1,
   parameter int PI_W    = 3,
   parameter int TAP_W   = 4,
   parameter int CLK_W   = 2,
   parameter int PI_MAX  = 6,
   parameter int CLK_MAX = 2
) (
   input  logic             cur_coarse,
   input  logic [CLK_W-1:0] cur_clk,
   input  logic [TAP_W-1:0] cur_tap,
   input  logic [PI_W-1:0]  cur_pi,
   input  logic [TAP_W-1:0] tap_max,
   output logic             nx_coarse,
   output logic [CLK_W-1:0] nx_clk,
   output logic [TAP_W-1:0] nx_tap,
   output logic [PI_W-1:0]  nx_pi,
   output logic             ok
);

   localparam logic [PI_W-1:0]  PI_TOP  = PI_W'(PI_MAX);
   localparam logic [CLK_W-1:0] CLK_TOP = CLK_W'(CLK_MAX);

   if (DIR_UP) begin : g_up
      always_comb begin
         nx_coarse = cur_coarse;
         nx_clk    = cur_clk;
         nx_tap    = cur_tap;
         nx_pi     = cur_pi;
         ok        = 1'b1;
         if (cur_pi < PI_TOP) begin
            nx_pi = cur_pi + 1'b1;
         end else if (cur_tap < tap_max) begin
            nx_pi  = '0;
            nx_tap = cur_tap + 1'b1;
         end else if (cur_clk < CLK_TOP) begin
            nx_pi  = '0;
            nx_tap = '0;
            nx_clk = cur_clk + 1'b1;
         end else if (!cur_coarse) begin
            // coarse rollover steps the clock-delay field back by one
            nx_pi     = '0;
            nx_tap    = '0;
            nx_clk    = cur_clk - 1'b1;
            nx_coarse = 1'b1;
         end else begin
            ok = 1'b0;
         end
      end
   end else begin : g_dn
      always_comb begin
         nx_coarse = cur_coarse;
         nx_clk    = cur_clk;
         nx_tap    = cur_tap;
         nx_pi     = cur_pi;
         ok        = 1'b1;
         if (cur_pi != '0) begin
            nx_pi = cur_pi - 1'b1;
         end else if (cur_tap != '0) begin
            nx_pi  = PI_TOP;
            nx_tap = cur_tap - 1'b1;
         end else if (cur_clk != '0) begin
            nx_pi  = PI_TOP;
            nx_tap = tap_max;
            nx_clk = cur_clk - 1'b1;
         end else if (cur_coarse) begin
            nx_pi     = PI_TOP;
            nx_tap    = tap_max;
            nx_clk    = cur_clk + 1'b1;
            nx_coarse = 1'b0;
         end else begin
            ok = 1'b0;
         end
      end
   end

endmodule

// File: rtl/dly_boost_decode.sv
module dly_boost_decode #(
   parameter int TAP_W = 4,
   parameter int PI_W  = 3
) (
   input  logic [TAP_W-1:0] tap,
   input  logic [PI_W-1:0]  pi,
   input  logic [TAP_W-1:0] th_tap_lo,
   input  logic [TAP_W-1:0] th_tap_hi,
   input  logic [PI_W-1:0]  th_pi_lo,
   input  logic [PI_W-1:0]  th_pi_hi,
   output logic             en,
   output logic             sel
);

   logic below_lo, below_hi;

   assign below_lo = (tap < th_tap_lo) || ((tap == th_tap_lo) && (pi < th_pi_lo));
   assign below_hi = (tap < th_tap_hi) || ((tap == th_tap_hi) && (pi < th_pi_hi));

   always_comb begin
      if (below_lo) begin
         en  = 1'b1;
         sel = 1'b1;
      end else if (below_hi) begin
         en  = 1'b0;
         sel = 1'b0;
      end else begin
         en  = 1'b1;
         sel = 1'b0;
      end
   end

endmodule

// File: rtl/dly_code_stepper.sv
module dly_code_stepper #(
   parameter int SPD_W   = 2,
   parameter int PI_W    = 3,
   parameter int TAP_W   = 4,
   parameter int CLK_W   = 2,
   parameter int PI_MAX  = 6,
   parameter int CLK_MAX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SPD_W-1:0] speed_sel,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             load_stb,
   input  logic             load_coarse,
   input  logic [CLK_W-1:0] load_clk,
   input  logic [TAP_W-1:0] load_tap,
   input  logic [PI_W-1:0]  load_pi,
   output logic             out_coarse,
   output logic [CLK_W-1:0] out_clk,
   output logic [TAP_W-1:0] out_tap,
   output logic [PI_W-1:0]  out_pi,
   output logic             boost_en,
   output logic             boost_sel,
   output logic             step_err,
   output logic             proto_err
);

   if (PI_MAX >= (1 << PI_W)) begin : g_pi_bad
      $error("dly_code_stepper: PI_MAX does not fit PI_W");
   end
   if (CLK_MAX >= (1 << CLK_W) || CLK_MAX < 1) begin : g_clk_bad
      $error("dly_code_stepper: CLK_MAX out of range for CLK_W");
   end
   if (SPD_W < 2) begin : g_spd_bad
      $error("dly_code_stepper: SPD_W must cover three grades");
   end

   logic [TAP_W-1:0] tap_max, th_tap_lo, th_tap_hi;
   logic [PI_W-1:0]  th_pi_lo, th_pi_hi;

   dly_speed_table #(.SPD_W(SPD_W), .TAP_W(TAP_W), .PI_W(PI_W)) u_tab (
      .speed_sel (speed_sel),
      .tap_max   (tap_max),
      .th_tap_lo (th_tap_lo),
      .th_tap_hi (th_tap_hi),
      .th_pi_lo  (th_pi_lo),
      .th_pi_hi  (th_pi_hi)
   );

   logic             up_coarse, dn_coarse;
   logic [CLK_W-1:0] up_clk, dn_clk;
   logic [TAP_W-1:0] up_tap, dn_tap;
   logic [PI_W-1:0]  up_pi, dn_pi;
   logic             up_ok, dn_ok;

   dly_step_path #(.DIR_UP(1'b1), .PI_W(PI_W), .TAP_W(TAP_W), .CLK_W(CLK_W),
                   .PI_MAX(PI_MAX), .CLK_MAX(CLK_MAX)) u_up (
      .cur_coarse (out_coarse), .cur_clk (out_clk), .cur_tap (out_tap), .cur_pi (out_pi),
      .tap_max    (tap_max),
      .nx_coarse  (up_coarse), .nx_clk (up_clk), .nx_tap (up_tap), .nx_pi (up_pi),
      .ok         (up_ok)
   );

   dly_step_path #(.DIR_UP(1'b0), .PI_W(PI_W), .TAP_W(TAP_W), .CLK_W(CLK_W),
                   .PI_MAX(PI_MAX), .CLK_MAX(CLK_MAX)) u_dn (
      .cur_coarse (out_coarse), .cur_clk (out_clk), .cur_tap (out_tap), .cur_pi (out_pi),
      .tap_max    (tap_max),
      .nx_coarse  (dn_coarse), .nx_clk (dn_clk), .nx_tap (dn_tap), .nx_pi (dn_pi),
      .ok         (dn_ok)
   );

   // candidate code: load wins, then the single active direction
   logic             do_up, do_dn, clash;
   logic             cand_coarse;
   logic [CLK_W-1:0] cand_clk;
   logic [TAP_W-1:0] cand_tap;
   logic [PI_W-1:0]  cand_pi;
   logic             cand_ok;
   logic             cand_en, cand_sel;

   assign do_up = step_up & ~step_dn & ~load_stb;
   assign do_dn = step_dn & ~step_up & ~load_stb;
   assign clash = step_up & step_dn & ~load_stb;

   always_comb begin
      if (load_stb) begin
         cand_coarse = load_coarse;
         cand_clk    = load_clk;
         cand_tap    = load_tap;
         cand_pi     = load_pi;
         cand_ok     = 1'b1;
      end else if (do_up) begin
         cand_coarse = up_coarse;
         cand_clk    = up_clk;
         cand_tap    = up_tap;
         cand_pi     = up_pi;
         cand_ok     = up_ok;
      end else begin
         cand_coarse = dn_coarse;
         cand_clk    = dn_clk;
         cand_tap    = dn_tap;
         cand_pi     = dn_pi;
         cand_ok     = dn_ok;
      end
   end

   dly_boost_decode #(.TAP_W(TAP_W), .PI_W(PI_W)) u_boost (
      .tap       (cand_tap),
      .pi        (cand_pi),
      .th_tap_lo (th_tap_lo),
      .th_tap_hi (th_tap_hi),
      .th_pi_lo  (th_pi_lo),
      .th_pi_hi  (th_pi_hi),
      .en        (cand_en),
      .sel       (cand_sel)
   );

   logic commit;
   assign commit = load_stb | ((do_up | do_dn) & cand_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_coarse <= 1'b0;
         out_clk    <= '0;
         out_tap    <= '0;
         out_pi     <= '0;
         boost_en   <= 1'b1;
         boost_sel  <= 1'b1;
         step_err   <= 1'b0;
         proto_err  <= 1'b0;
      end else begin
         step_err  <= (do_up | do_dn) & ~cand_ok;
         proto_err <= clash;
         if (commit) begin
            out_coarse <= cand_coarse;
            out_clk    <= cand_clk;
            out_tap    <= cand_tap;
            out_pi     <= cand_pi;
            boost_en   <= cand_en;
            boost_sel  <= cand_sel;
         end
      end
   end

endmodule

// File: rtl/dly_code_stepper_chk.sv
module dly_code_stepper_chk #(
   parameter int PI_W   = 3,
   parameter int TAP_W  = 4,
   parameter int CLK_W  = 2,
   parameter int PI_MAX = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_up,
   input logic             step_dn,
   input logic             load_stb,
   input logic             out_coarse,
   input logic [CLK_W-1:0] out_clk,
   input logic [TAP_W-1:0] out_tap,
   input logic [PI_W-1:0]  out_pi,
   input logic             boost_en,
   input logic             boost_sel,
   input logic             step_err,
   input logic             proto_err
);

   // R9
   both_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && step_dn && !load_stb) |=> (proto_err && !step_err &&
         $stable(out_pi) && $stable(out_tap) && $stable(out_clk) && $stable(out_coarse)));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_err |-> ($stable(out_pi) && $stable(out_tap) && $stable(out_clk) &&
                    $stable(out_coarse) && $stable(boost_en) && $stable(boost_sel)));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_up && !step_dn && !load_stb) |=> (!step_err && !proto_err &&
         $stable(out_pi) && $stable(out_tap) && $stable(out_clk) && $stable(out_coarse) &&
         $stable(boost_en) && $stable(boost_sel)));

   // R3
   pi_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !step_dn && !load_stb && (int'(out_pi) < PI_MAX))
         |=> (int'(out_pi) == int'($past(out_pi)) + 1));

   // R6
   boost_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!boost_en && boost_sel));

   // R8
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_err && proto_err));

endmodule

bind dly_code_stepper dly_code_stepper_chk #(
   .PI_W(PI_W), .TAP_W(TAP_W), .CLK_W(CLK_W), .PI_MAX(PI_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn), .load_stb(load_stb),
   .out_coarse(out_coarse), .out_clk(out_clk), .out_tap(out_tap), .out_pi(out_pi),
   .boost_en(boost_en), .boost_sel(boost_sel), .step_err(step_err), .proto_err(proto_err)
);

// File: tb/sim_dly_code_stepper.sv
`timescale 1ns/1ps
module sim_dly_code_stepper;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] speed_sel = '0;
   logic       step_up = 1'b0, step_dn = 1'b0, load_stb = 1'b0;
   logic       load_coarse = 1'b0;
   logic [1:0] load_clk = '0;
   logic [3:0] load_tap = '0;
   logic [2:0] load_pi = '0;
   logic       out_coarse;
   logic [1:0] out_clk;
   logic [3:0] out_tap;
   logic [2:0] out_pi;
   logic       boost_en, boost_sel, step_err, proto_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dly_code_stepper u0 (
      .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel),
      .step_up(step_up), .step_dn(step_dn), .load_stb(load_stb),
      .load_coarse(load_coarse), .load_clk(load_clk), .load_tap(load_tap), .load_pi(load_pi),
      .out_coarse(out_coarse), .out_clk(out_clk), .out_tap(out_tap), .out_pi(out_pi),
      .boost_en(boost_en), .boost_sel(boost_sel), .step_err(step_err), .proto_err(proto_err)
   );

   // op: 0 idle, 1 up, 2 down, 3 up+down, 4 load, 5 load+up+down
   typedef struct packed {
      logic [2:0] op;  logic [1:0] spd;
      logic lc; logic [1:0] lk; logic [3:0] lt; logic [2:0] lp;
      logic ec; logic [1:0] ek; logic [3:0] et; logic [2:0] ep;
      logic ben; logic bsel; logic eerr; logic eperr;
   } vec_t;

   localparam int NV = 37;
   localparam vec_t TBL [NV] = '{
      '{4,0, 0,0,0,0,   0,0,0,0,   1,1,0,0},  // R2 load zero
      '{1,0, 0,0,0,0,   0,0,0,1,   1,1,0,0},  // R3 pi up
      '{4,0, 0,0,3,1,   0,0,3,1,   1,1,0,0},  // R6 tap==t0, pi<p0
      '{1,0, 0,0,0,0,   0,0,3,2,   0,0,0,0},  // R6 middle band
      '{4,0, 0,0,10,2,  0,0,10,2,  0,0,0,0},  // R6 tap==t1, pi<p1
      '{1,0, 0,0,0,0,   0,0,10,3,  1,0,0,0},  // R6 upper band
      '{4,0, 0,0,12,6,  0,0,12,6,  1,0,0,0},  // R2
      '{1,0, 0,0,0,0,   0,1,0,0,   1,1,0,0},  // R3 carry into clock-delay
      '{2,0, 0,0,0,0,   0,0,12,6,  1,0,0,0},  // R4 borrow from clock-delay
      '{4,0, 0,2,12,6,  0,2,12,6,  1,0,0,0},  // R2
      '{1,0, 0,0,0,0,   1,1,0,0,   1,1,0,0},  // R3 coarse rollover
      '{2,0, 0,0,0,0,   1,0,12,6,  1,0,0,0},  // R4
      '{4,0, 1,0,0,0,   1,0,0,0,   1,1,0,0},  // R2
      '{2,0, 0,0,0,0,   0,1,12,6,  1,0,0,0},  // R4 coarse borrow
      '{4,0, 0,0,0,0,   0,0,0,0,   1,1,0,0},  // R2
      '{2,0, 0,0,0,0,   0,0,0,0,   1,1,1,0},  // R8 underflow
      '{4,0, 1,2,12,6,  1,2,12,6,  1,0,0,0},  // R2
      '{1,0, 0,0,0,0,   1,2,12,6,  1,0,1,0},  // R8 overflow
      '{3,0, 0,0,0,0,   1,2,12,6,  1,0,0,1},  // R9 both commands
      '{0,0, 0,0,0,0,   1,2,12,6,  1,0,0,0},  // R7 idle clears pulses
      '{4,1, 0,0,10,6,  0,0,10,6,  1,0,0,0},  // R5 grade 1
      '{1,1, 0,0,0,0,   0,1,0,0,   1,1,0,0},  // R5 max tap 10
      '{4,1, 0,0,2,5,   0,0,2,5,   1,1,0,0},  // R6 grade 1 low
      '{1,1, 0,0,0,0,   0,0,2,6,   0,0,0,0},  // R6
      '{4,1, 0,0,8,6,   0,0,8,6,   0,0,0,0},  // R6 tap==t1
      '{1,1, 0,0,0,0,   0,0,9,0,   1,0,0,0},  // R6
      '{4,2, 0,0,13,6,  0,0,13,6,  1,0,0,0},  // R5 grade 2
      '{1,2, 0,0,0,0,   0,1,0,0,   1,1,0,0},  // R5 max tap 13
      '{4,2, 0,0,11,3,  0,0,11,3,  0,0,0,0},  // R6 grade 2
      '{1,2, 0,0,0,0,   0,0,11,4,  1,0,0,0},  // R6
      '{2,2, 0,0,0,0,   0,0,11,3,  0,0,0,0},  // R6 recomputed on down
      '{4,2, 0,0,3,5,   0,0,3,5,   1,1,0,0},  // R6
      '{1,2, 0,0,0,0,   0,0,3,6,   0,0,0,0},  // R6
      '{4,3, 0,0,12,6,  0,0,12,6,  1,0,0,0},  // R5 code 3
      '{1,3, 0,0,0,0,   0,1,0,0,   1,1,0,0},  // R5 code 3 uses 12
      '{4,0, 0,0,9,0,   0,0,9,0,   0,0,0,0},  // R7 setup
      '{0,1, 0,0,0,0,   0,0,9,0,   0,0,0,0}   // R7 speed change alone
   };

   function automatic int max_tap_of(input int s);
      return (s == 1) ? 10 : (s == 2) ? 13 : 12;
   endfunction

   function automatic int boost_of(input int s, input int t, input int p);
      int t0, t1, p0, p1;
      case (s)
         1: begin t0 = 2; t1 = 8;  p0 = 6; p1 = 7; end
         2: begin t0 = 3; t1 = 11; p0 = 6; p1 = 4; end
         default: begin t0 = 3; t1 = 10; p0 = 2; p1 = 3; end
      endcase
      if (t < t0 || (t == t0 && p < p0)) return 3;
      if (t < t1 || (t == t1 && p < p1)) return 0;
      return 2;
   endfunction

   task automatic check(input string req, input int got, input int exp_v);
      checks++;
      if (got != exp_v) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp_v);
      end
   endtask

   // drive at negedge, result visible by the following negedge
   task automatic apply(input int op, input int spd, input int lc, input int lk,
                        input int lt, input int lp);
      speed_sel   = 2'(spd);
      step_up     = (op == 1 || op == 3 || op == 5);
      step_dn     = (op == 2 || op == 3 || op == 5);
      load_stb    = (op == 4 || op == 5);
      load_coarse = 1'(lc);
      load_clk    = 2'(lk);
      load_tap    = 4'(lt);
      load_pi     = 3'(lp);
      @(posedge clk);
      @(negedge clk);
      step_up = 1'b0; step_dn = 1'b0; load_stb = 1'b0;
   endtask

   function automatic int snap();
      return {out_coarse, out_clk, out_tap, out_pi, boost_en, boost_sel, step_err, proto_err};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check("R1 in reset", snap(), 14'b0_00_0000_000_1_1_0_0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", snap(), 14'b0_00_0000_000_1_1_0_0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(TBL[i].op, TBL[i].spd, TBL[i].lc, TBL[i].lk, TBL[i].lt, TBL[i].lp);
         check($sformatf("R2-vector %0d", i), snap(),
               {TBL[i].ec, TBL[i].ek, TBL[i].et, TBL[i].ep,
                TBL[i].ben, TBL[i].bsel, TBL[i].eerr, TBL[i].eperr});
      end

      // load with both step lines: load wins, no protocol pulse (R2)
      apply(5, 0, 0, 1, 4, 4);
      check("R2 load priority", snap(), {1'b0, 2'd1, 4'd4, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0});

      // full sweeps per speed code (R3, R4, R5, R6)
      for (int s = 0; s < 4; s++) begin
         int m, n, bad;
         m = max_tap_of(s);
         apply(4, s, 0, 0, 0, 0);
         n = 0; bad = 0;
         while (n < 1000) begin
            apply(1, s, 0, 0, 0, 0);
            if (step_err) break;
            n++;
            if (int'({boost_en, boost_sel}) != boost_of(s, out_tap, out_pi)) bad++;
         end
         check($sformatf("R5 up sweep length spd %0d", s), n, 35 * (m + 1) - 1);
         check("R3 top code", snap(), {1'b1, 2'd2, 4'(m), 3'd6, 2'(boost_of(s, m, 6)), 1'b1, 1'b0});
         check("R6 boost along up sweep", bad, 0);
         n = 0; bad = 0;
         while (n < 1000) begin
            apply(2, s, 0, 0, 0, 0);
            if (step_err) break;
            n++;
            if (int'({boost_en, boost_sel}) != boost_of(s, out_tap, out_pi)) bad++;
         end
         check($sformatf("R4 down sweep length spd %0d", s), n, 35 * (m + 1) - 1);
         check("R4 bottom code", snap(), {1'b0, 2'd0, 4'd0, 3'd0, 2'd3, 1'b1, 1'b0});
         check("R6 boost along down sweep", bad, 0);
      end

      // reset in the middle restores the idle code (R1)
      apply(4, 2, 1, 1, 7, 3);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", snap(), 14'b0_00_0000_000_1_1_0_0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule